// File: doc/BRIEF.md
# Entry-Compare Gated Register Pipeline

This block is a chain of data registers in which each stage is clocked by its own gated clock. The decision to clock a stage comes from a single equality comparator at the head of the chain. The comparator looks at the incoming word and the word already held in the first stage. If the two differ and the first stage is enabled, the first stage receives one clock pulse.

That decision then moves down the chain through one-bit flags clocked by the free-running clock, one stage per cycle, in step with the word it belongs to. A later stage is clocked only in the cycle after its upstream neighbour actually captured a new word, and only while its own enable is set. Long runs of repeated input therefore stop all register clocking once the last changed word has settled in the final stage.

Each gated clock is built from a latch that is open while the clock is low, followed by an AND with the clock. An enable that changes during the high phase cannot shorten or split a pulse. The gated clocks are brought out so that a system can observe them.

Top module: `scg_pipe`

## Requirements
- R1: An active-low `rst_n` asynchronously clears every stage register and every forwarded change flag, so `dout` reads 0 during reset. With `din` at 0 after release, no gated clock pulses.
- R2: Stage 0 receives a pulse on `gclk[0]` at a rising clock edge exactly when `en[0]` is 1 and `din` differs from the word held in stage 0. After any edge at which `en[0]` is 1, stage 0 holds the `din` of that edge.
- R3: Stage i > 0 receives a pulse on `gclk[i]` at a rising edge exactly when stage i-1 was pulsed at the previous edge and `en[i]` is 1. On that pulse it captures the word held in stage i-1.
- R4: A stage whose enable bit is 0 at a rising edge gets no gated pulse and keeps its word. When `en[2]` is 0, `dout` does not change at that edge.
- R5: Every gated clock is low whenever `clk` is low.
- R6: With all enables held at 1, `dout` after rising edge k equals the `din` presented at edge k-2, giving a latency of three edges counting the capture edge. After an enable was cleared, this holds again once a value that differs from stage 0 has entered with all enables set and travelled through.
- R7: With all enables at 1 and `din` held constant, no gated clock pulses from the fourth edge of the run onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | NUM_STAGES | Per-stage clock enable, bit i for stage i |
| din | input | DATA_W | Word entering stage 0 |
| dout | output | DATA_W | Word held in the last stage |
| gclk | output | NUM_STAGES | Gated clock of each stage, for observation |

## Verification
A gated pulse is due at the first rising edge after its cause is presented: for stage 0 it follows that cycle's `din` and `en[0]`, and for stage i it follows the previous edge's pulse of stage i-1. The bench therefore compares the pulses counted between two falling edges with a per-stage expectation formed when the inputs were driven. `dout` is due three edges after the capture of a word, so it is compared with the value driven three falling edges earlier, and only while the bench's resynchronisation counter shows that every stage has been refilled. The hold check for a disabled last stage compares `dout` at consecutive falling edges. The low-phase check reads the gated clocks half a nanosecond after each falling edge.

// File: rtl/scg_pkg.sv
package scg_pkg;

   // Smallest legal configuration of the entry-compare pipeline.
   localparam int SCG_MIN_STAGES = 2;
   localparam int SCG_MIN_WIDTH  = 1;

   // Source of a stage's change flag.
   typedef enum logic {
      SCG_SRC_COMPARE = 1'b0,
      SCG_SRC_FORWARD = 1'b1
   } scg_src_e;

endpackage

// File: rtl/scg_clock_gate.sv
module scg_clock_gate (
   input  logic clk_i,
   input  logic en_i,
   output logic gclk_o
);

   logic en_held;

   // Open during the low phase, closed while clk_i is high.
   always_latch begin
      if (!clk_i) en_held = en_i;
   end

   assign gclk_o = clk_i & en_held;

endmodule

// File: rtl/scg_data_stage.sv
module scg_data_stage #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              chg_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o,
   output logic              gclk_o
);

   logic fire_req;

   assign fire_req = en_i & chg_i;

   scg_clock_gate u_gate (
      .clk_i  (clk_i),
      .en_i   (fire_req),
      .gclk_o (gclk_o)
   );

   always_ff @(posedge gclk_o or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
   end

endmodule

// File: rtl/scg_pipe.sv
module scg_pipe #(
   parameter int DATA_W     = 8,
   parameter int NUM_STAGES = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STAGES-1:0] en,
   input  logic [DATA_W-1:0]     din,
   output logic [DATA_W-1:0]     dout,
   output logic [NUM_STAGES-1:0] gclk
);
   import scg_pkg::*;

   localparam int LAST = NUM_STAGES - 1;

   if (NUM_STAGES < SCG_MIN_STAGES) begin : g_bad_depth
      $error("scg_pipe: NUM_STAGES below minimum");
   end
   if (DATA_W < SCG_MIN_WIDTH) begin : g_bad_width
      $error("scg_pipe: DATA_W below minimum");
   end

   logic [DATA_W-1:0]     stage_d [NUM_STAGES];
   logic [DATA_W-1:0]     stage_q [NUM_STAGES];
   logic [NUM_STAGES-1:0] chg;
   logic [NUM_STAGES-1:0] fired;

   assign fired = en & chg;

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      localparam scg_src_e SRC = (i == 0) ? SCG_SRC_COMPARE : SCG_SRC_FORWARD;

      if (SRC == SCG_SRC_COMPARE) begin : g_cmp
         // Only comparator in the chain: new word versus held word.
         assign chg[i]     = |(din ^ stage_q[i]);
         assign stage_d[i] = din;
      end else begin : g_fwd
         logic flag_q;
         // Remembers that the upstream stage captured at the last edge.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= fired[i-1];
         end
         assign chg[i]     = flag_q;
         assign stage_d[i] = stage_q[i-1];
      end

      scg_data_stage #(.DATA_W(DATA_W)) u_stage (
         .clk_i  (clk),
         .rst_ni (rst_n),
         .en_i   (en[i]),
         .chg_i  (chg[i]),
         .d_i    (stage_d[i]),
         .q_o    (stage_q[i]),
         .gclk_o (gclk[i])
      );
   end

   assign dout = stage_q[LAST];

endmodule

// File: rtl/scg_pipe_chk.sv
module scg_pipe_chk #(
   parameter int DATA_W     = 8,
   parameter int NUM_STAGES = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_STAGES-1:0] en,
   input logic [DATA_W-1:0]     din,
   input logic [DATA_W-1:0]     dout,
   input logic [NUM_STAGES-1:0] gclk,
   input logic [NUM_STAGES-1:0] chg,
   input logic [DATA_W-1:0]     head_q
);

   // R5: gated clocks sampled just before a rising edge are low.
   p_gclk_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gclk == '0);

   // R4: a disabled last stage leaves dout untouched.
   p_hold_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en[NUM_STAGES-1] |=> $stable(dout));

   // R2: an enabled head stage ends up holding the presented word.
   p_head_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en[0] |=> (head_q == $past(din)));

   // R3: a head capture raises the next stage's change flag.
   p_change_forward_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en[0] && chg[0]) |=> chg[1]);

   // R3: without a head capture the next flag stays low.
   p_no_spurious_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(en[0] && chg[0]) |=> !chg[1]);

endmodule

bind scg_pipe scg_pipe_chk #(
   .DATA_W     (DATA_W),
   .NUM_STAGES (NUM_STAGES)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .din    (din),
   .dout   (dout),
   .gclk   (gclk),
   .chg    (chg),
   .head_q (stage_q[0])
);

// File: tb/scg_pipe_tb.sv
`timescale 1ns/1ps
module scg_pipe_tb;
   localparam int W = 8;
   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] en = '0;
   logic [W-1:0] din = '0;
   wire  [W-1:0] dout;
   wire  [N-1:0] gclk;

   scg_pipe #(.DATA_W(W), .NUM_STAGES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout), .gclk(gclk)
   );

   always #2.5 clk = ~clk;

   int pc0, pc1, pc2;
   always @(posedge gclk[0]) pc0++;
   always @(posedge gclk[1]) pc1++;
   always @(posedge gclk[2]) pc2++;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   logic [W-1:0] m_head;
   logic [W-1:0] hist [3];
   logic [W-1:0] dout_last;
   bit   [N-1:0] ep;
   bit           prev_hold;
   int           sync_cnt;
   bit           need_force;

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_head = '0;
      for (int i = 0; i < 3; i++) hist[i] = '0;
      dout_last = '0; ep = '0; prev_hold = 0;
      sync_cnt = 3; need_force = 0;
      pc0 = 0; pc1 = 0; pc2 = 0;
   endtask

   task automatic tick(input logic [N-1:0] e, input logic [W-1:0] d_in);
      logic [W-1:0] d;
      bit [N-1:0]   nxt;
      d = d_in;
      @(negedge clk);
      #0.5;
      chk("R5 gated clocks low in low phase", int'(gclk), 0);
      chk("R2 head stage pulse count", pc0, int'(ep[0]));
      chk("R3 R4 stage 1 pulse count", pc1, int'(ep[1]));
      chk("R3 R4 R7 stage 2 pulse count", pc2, int'(ep[2]));
      if (sync_cnt >= 3) chk("R6 dout three-edge latency", int'(dout), int'(hist[2]));
      if (prev_hold) chk("R4 dout held while last stage disabled", int'(dout), int'(dout_last));
      dout_last = dout;
      pc0 = 0; pc1 = 0; pc2 = 0;
      if ((&e) && need_force && d == m_head) d = ~m_head;
      nxt[0] = e[0] && (d != m_head);
      nxt[1] = e[1] && ep[0];
      nxt[2] = e[2] && ep[1];
      ep = nxt;
      if (e[0]) m_head = d;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = d;
      if (!(&e)) begin
         sync_cnt = 0; need_force = 1;
      end else if (need_force) begin
         need_force = 0; sync_cnt = 1;
      end else if (sync_cnt < 3) begin
         sync_cnt++;
      end
      prev_hold = !e[2];
      en = e;
      din = d;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] cur;
      void'($urandom(32'h5eed_2c01));
      model_reset();
      repeat (3) @(negedge clk);
      #0.5;
      chk("R1 dout cleared in reset", int'(dout), 0);
      chk("R1 no pulses in reset", pc0 + pc1 + pc2, 0);
      rst_n = 1'b1;
      model_reset();

      // Directed: first word through the chain, then a steady run (R6, R7).
      tick('1, 8'h00);
      tick('1, 8'hA5);
      for (int i = 0; i < 8; i++) tick('1, 8'hA5);
      tick('1, 8'h5A);
      tick('1, 8'h5A);

      // Random data with long repeat runs, all enabled.
      cur = 8'h5A;
      for (int i = 0; i < 300; i++) begin
         if ($urandom_range(0, 99) < 35) cur = 8'($urandom);
         if ($urandom_range(0, 99) < 5) begin
            for (int k = 0; k < int'($urandom_range(5, 12)); k++) tick('1, cur);
         end
         tick('1, cur);
      end

      // Random enables mixed with resynchronising all-enabled stretches.
      for (int blk = 0; blk < 40; blk++) begin
         for (int i = 0; i < 6; i++) begin
            if ($urandom_range(0, 99) < 50) cur = 8'($urandom);
            tick(N'($urandom_range(0, 7)), cur);
         end
         for (int i = 0; i < 6; i++) begin
            if ($urandom_range(0, 99) < 40) cur = 8'($urandom);
            tick('1, cur);
         end
      end

      // Directed: last stage off while words arrive (R4).
      tick(3'b011, 8'h11);
      tick(3'b011, 8'h22);
      tick(3'b011, 8'h33);
      tick('1, 8'h44);
      for (int i = 0; i < 5; i++) tick('1, 8'h44);

      // Reset in mid-run clears everything (R1).
      @(negedge clk);
      rst_n = 1'b0;
      en = '0;
      din = '0;
      @(negedge clk);
      #0.5;
      chk("R1 dout cleared by reset mid-run", int'(dout), 0);
      rst_n = 1'b1;
      model_reset();
      for (int i = 0; i < 5; i++) tick('1, 8'h00);
      tick('1, 8'hFF);
      for (int i = 0; i < 5; i++) tick('1, 8'hFF);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule